// File: doc/BRIEF.md
# Fault-Aware Dimension-Ordered Route Selector

This unit decides the output port of one mesh router for the flit at the head of a packet. It takes the router's own column and row, the destination column and row, and a fault flag for each of the four neighbours. It returns one output direction. With a healthy neighbourhood it follows the usual order: it first closes the column gap, then the row gap, and it delivers to the local port on arrival. A neighbour can be flagged as down. If the neighbour the packet would normally take is down, the unit steps onto the perpendicular axis instead.

The unit is purely combinational. It decides in the same cycle that the header coordinates are presented. It never points a packet off the mesh edge and never at a faulty neighbour. When every candidate is ruled out it raises a no-route flag and drives no direction.

Internally a mode is chosen from the coordinate comparison: ARRIVED (both coordinates match), XAXIS (the columns differ) or YAXIS (the columns match and the rows differ). In XAXIS the preferred horizontal port is taken if it is legal. Otherwise the unit moves to the vertical fallback: first the port toward the destination row, then the opposite vertical port. When the rows match, South is tried first. In YAXIS the preferred vertical port is taken if it is legal. Otherwise the unit tries East and then West. ARRIVED always yields the local port.

Top module: `xy_fault_route`

## Requirements
- R1: When cur_x==dst_x and cur_y==dst_y, route_dir is 5'b00001 (local) and no_route is 0, whatever nbr_down holds.
- R2: When cur_x<dst_x, the unit selects East (route_dir 5'b00100) if East is legal. When cur_x>dst_x, it selects West (5'b10000) if West is legal. A port is legal when its nbr_down bit is 0 and it does not cross the mesh edge.
- R3: When the columns match, cur_y<dst_y selects South (5'b01000) and cur_y>dst_y selects North (5'b00010), provided that port is legal. Row 0 is the northern edge.
- R4: When the columns differ and the preferred horizontal port is not legal, the vertical port toward dst_y is taken if legal. Otherwise the opposite vertical port is taken if legal.
- R5: In the R4 detour with cur_y==dst_y, South is taken if legal, otherwise North.
- R6: When the columns match, the rows differ and the preferred vertical port is not legal, East is taken if legal, otherwise West.
- R7: A port that crosses the mesh edge is never selected: North at cur_y==0, South at cur_y==MESH_ROWS-1, West at cur_x==0, East at cur_x==MESH_COLS-1.
- R8: A port whose nbr_down bit is 1 is never selected. nbr_down bit 0 is North, bit 1 East, bit 2 South and bit 3 West. When no candidate is legal, no_route is 1 and route_dir is 0.
- R9: route_dir is one-hot whenever no_route is 0. Bit 0 is Local, bit 1 North, bit 2 East, bit 3 South and bit 4 West.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_x | input | XW | Column of this router (0 = western edge) |
| cur_y | input | YW | Row of this router (0 = northern edge) |
| dst_x | input | XW | Destination column from the header flit |
| dst_y | input | YW | Destination row from the header flit |
| nbr_down | input | 4 | Neighbour fault flags {W,S,E,N} |
| route_dir | output | 5 | One-hot chosen port {W,S,E,N,Local} |
| no_route | output | 1 | No legal port exists for this header |

## Verification
The bench first sweeps every source and destination pair on the default 4x4 mesh with no faults. A correct result there separates strict column-first ordering from row-first ordering and from swapped compass signs. Directed fault patterns then block the preferred port in the interior, where they show whether the fallback goes toward the destination row or away from it. They also block it on edges and corners, where the South-before-North and East-before-West preferences have to yield to the boundary. Patterns with every neighbour down, both at the destination and away from it, separate the local delivery case from the no-route case.

// File: rtl/xyr_pkg.sv
package xyr_pkg;

    localparam int NUM_DIRS = 5;
    localparam int NUM_NBRS = 4;

    typedef enum logic [2:0] {
        DIR_LOCAL = 3'd0,
        DIR_NORTH = 3'd1,
        DIR_EAST  = 3'd2,
        DIR_SOUTH = 3'd3,
        DIR_WEST  = 3'd4
    } dir_e;

    typedef enum logic [1:0] {
        MODE_ARRIVED = 2'd0,
        MODE_XAXIS   = 2'd1,
        MODE_YAXIS   = 2'd2
    } mode_e;

    function automatic logic [NUM_DIRS-1:0] dir_onehot(input dir_e d);
        logic [NUM_DIRS-1:0] v;
        v = '0;
        v[d] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/xyr_axis_cmp.sv
module xyr_axis_cmp #(
    parameter int W = 2
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] dst,
    output logic         lt,
    output logic         gt
);

    always_comb begin
        lt = (cur < dst);
        gt = (cur > dst);
    end

    // R9 depends on the comparator never claiming both orderings at once
    always_comb begin
        assert_cmp_exclusive_R9: assert (!(lt && gt));
    end

endmodule

// File: rtl/xyr_port_legal.sv
module xyr_port_legal
    import xyr_pkg::*;
#(
    parameter int COLS = 4,
    parameter int ROWS = 4,
    parameter int XW   = 2,
    parameter int YW   = 2
) (
    input  logic [XW-1:0]       cur_x,
    input  logic [YW-1:0]       cur_y,
    input  logic [NUM_NBRS-1:0] nbr_down,
    output logic [NUM_DIRS-1:0] legal
);

    localparam logic [XW-1:0] X_LAST = XW'(COLS - 1);
    localparam logic [YW-1:0] Y_LAST = YW'(ROWS - 1);

    logic [NUM_NBRS-1:0] at_edge;

    // neighbour index g maps to direction g+1 (N, E, S, W)
    always_comb begin
        at_edge[0] = (cur_y == '0);
        at_edge[1] = (cur_x == X_LAST);
        at_edge[2] = (cur_y == Y_LAST);
        at_edge[3] = (cur_x == '0);
    end

    assign legal[DIR_LOCAL] = 1'b1;

    for (genvar g = 0; g < NUM_NBRS; g++) begin : g_nbr
        assign legal[g+1] = !nbr_down[g] && !at_edge[g];
    end

    always_comb begin
        assert_edge_west_R7:  assert (!(cur_x == '0 && legal[DIR_WEST]));
        assert_edge_north_R7: assert (!(cur_y == '0 && legal[DIR_NORTH]));
        assert_down_mask_R8:  assert ((legal[NUM_DIRS-1:1] & nbr_down) == '0);
    end

endmodule

// File: rtl/xyr_route_pick.sv
module xyr_route_pick
    import xyr_pkg::*;
(
    input  logic                x_lt,
    input  logic                x_gt,
    input  logic                y_lt,
    input  logic                y_gt,
    input  logic [NUM_DIRS-1:0] legal,
    output logic [NUM_DIRS-1:0] route_dir,
    output logic                no_route
);

    mode_e mode;
    dir_e  pick;
    logic  found;
    dir_e  pref_h;
    dir_e  pref_v;
    dir_e  alt_v;

    always_comb begin
        if (!x_lt && !x_gt && !y_lt && !y_gt) begin
            mode = MODE_ARRIVED;
        end else if (x_lt || x_gt) begin
            mode = MODE_XAXIS;
        end else begin
            mode = MODE_YAXIS;
        end
    end

    always_comb begin
        pref_h = x_lt ? DIR_EAST : DIR_WEST;
        pref_v = y_gt ? DIR_NORTH : DIR_SOUTH;
        alt_v  = y_gt ? DIR_SOUTH : DIR_NORTH;
    end

    // candidate selection per mode
    always_comb begin
        pick  = DIR_LOCAL;
        found = 1'b0;
        unique case (mode)
            MODE_ARRIVED: begin
                pick  = DIR_LOCAL;
                found = 1'b1;
            end
            MODE_XAXIS: begin
                if (legal[pref_h]) begin
                    pick  = pref_h;
                    found = 1'b1;
                end else if (legal[pref_v]) begin
                    pick  = pref_v;
                    found = 1'b1;
                end else if (legal[alt_v]) begin
                    pick  = alt_v;
                    found = 1'b1;
                end
            end
            MODE_YAXIS: begin
                if (legal[pref_v]) begin
                    pick  = pref_v;
                    found = 1'b1;
                end else if (legal[DIR_EAST]) begin
                    pick  = DIR_EAST;
                    found = 1'b1;
                end else if (legal[DIR_WEST]) begin
                    pick  = DIR_WEST;
                    found = 1'b1;
                end
            end
            default: begin
                pick  = DIR_LOCAL;
                found = 1'b0;
            end
        endcase
    end

    // output decode
    always_comb begin
        route_dir = found ? dir_onehot(pick) : '0;
        no_route  = !found;
    end

    always_comb begin
        assert_x_first_R2: assert (!((x_lt || x_gt) && legal[pref_h]) || route_dir == dir_onehot(pref_h));
        assert_y_detour_R6: assert (!(mode == MODE_YAXIS && !legal[pref_v] && legal[DIR_EAST])
                                    || route_dir[DIR_EAST]);
    end

endmodule

// File: rtl/xy_fault_route.sv
module xy_fault_route
    import xyr_pkg::*;
#(
    parameter int MESH_COLS = 4,
    parameter int MESH_ROWS = 4,
    localparam int XW = (MESH_COLS > 1) ? $clog2(MESH_COLS) : 1,
    localparam int YW = (MESH_ROWS > 1) ? $clog2(MESH_ROWS) : 1
) (
    input  logic [XW-1:0] cur_x,
    input  logic [YW-1:0] cur_y,
    input  logic [XW-1:0] dst_x,
    input  logic [YW-1:0] dst_y,
    input  logic [3:0]    nbr_down,
    output logic [4:0]    route_dir,
    output logic          no_route
);

    localparam logic [XW-1:0] X_LAST = XW'(MESH_COLS - 1);
    localparam logic [YW-1:0] Y_LAST = YW'(MESH_ROWS - 1);

    logic                x_lt, x_gt, y_lt, y_gt;
    logic [NUM_DIRS-1:0] legal;

    xyr_axis_cmp #(.W(XW)) u_cmp_x (
        .cur (cur_x),
        .dst (dst_x),
        .lt  (x_lt),
        .gt  (x_gt)
    );

    xyr_axis_cmp #(.W(YW)) u_cmp_y (
        .cur (cur_y),
        .dst (dst_y),
        .lt  (y_lt),
        .gt  (y_gt)
    );

    xyr_port_legal #(
        .COLS (MESH_COLS),
        .ROWS (MESH_ROWS),
        .XW   (XW),
        .YW   (YW)
    ) u_legal (
        .cur_x    (cur_x),
        .cur_y    (cur_y),
        .nbr_down (nbr_down),
        .legal    (legal)
    );

    xyr_route_pick u_pick (
        .x_lt      (x_lt),
        .x_gt      (x_gt),
        .y_lt      (y_lt),
        .y_gt      (y_gt),
        .legal     (legal),
        .route_dir (route_dir),
        .no_route  (no_route)
    );

    always_comb begin
        assert_local_iff_R1: assert (route_dir[DIR_LOCAL] == (cur_x == dst_x && cur_y == dst_y));
        assert_edge_east_R7: assert (!(route_dir[DIR_EAST] && cur_x == X_LAST));
        assert_edge_south_R7: assert (!(route_dir[DIR_SOUTH] && cur_y == Y_LAST));
        assert_never_down_R8: assert ((route_dir[4:1] & nbr_down) == 4'b0000);
        assert_noroute_zero_R8: assert (!no_route || route_dir == '0);
        assert_onehot_R9: assert (no_route || $onehot(route_dir));
    end

endmodule

// File: tb/xy_fault_route_bench.sv
module xy_fault_route_bench;

    localparam int COLS = 4;
    localparam int ROWS = 4;

    localparam logic [4:0] D_L = 5'b00001;
    localparam logic [4:0] D_N = 5'b00010;
    localparam logic [4:0] D_E = 5'b00100;
    localparam logic [4:0] D_S = 5'b01000;
    localparam logic [4:0] D_W = 5'b10000;
    localparam logic [4:0] D_0 = 5'b00000;

    localparam logic [3:0] B_N = 4'b0001;
    localparam logic [3:0] B_E = 4'b0010;
    localparam logic [3:0] B_S = 4'b0100;
    localparam logic [3:0] B_W = 4'b1000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cur_x = '0, cur_y = '0, dst_x = '0, dst_y = '0;
    logic [3:0] nbr_down = '0;
    logic [4:0] route_dir;
    logic       no_route;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    xy_fault_route #(.MESH_COLS(COLS), .MESH_ROWS(ROWS)) u_xy_fault_route (
        .cur_x     (cur_x),
        .cur_y     (cur_y),
        .dst_x     (dst_x),
        .dst_y     (dst_y),
        .nbr_down  (nbr_down),
        .route_dir (route_dir),
        .no_route  (no_route)
    );

    task automatic try_case(input string req, input int cx, input int cy, input int dx, input int dy,
                            input logic [3:0] blk, input logic [4:0] exp_dir, input logic exp_nr);
        @(negedge clk);
        cur_x = 2'(cx); cur_y = 2'(cy); dst_x = 2'(dx); dst_y = 2'(dy);
        nbr_down = blk;
        #1;
        n_checks++;
        if (route_dir !== exp_dir || no_route !== exp_nr) begin
            n_errors++;
            $display("FAIL %s cur=(%0d,%0d) dst=(%0d,%0d) down=%b: got dir=%b nr=%b, expected dir=%b nr=%b",
                     req, cx, cy, dx, dy, blk, route_dir, no_route, exp_dir, exp_nr);
        end
    endtask

    task automatic test_reset_state();
        // R1: start-up inputs all zero means arrived at (0,0)
        try_case("R1", 0, 0, 0, 0, 4'b0000, D_L, 1'b0);
    endtask

    task automatic test_arrival();
        try_case("R1", 2, 1, 2, 1, 4'b1111, D_L, 1'b0);
        try_case("R1", 3, 3, 3, 3, 4'b0101, D_L, 1'b0);
    endtask

    task automatic test_fault_free_sweep();
        // R2 and R3 over every pair with no faults
        for (int cx = 0; cx < COLS; cx++)
            for (int cy = 0; cy < ROWS; cy++)
                for (int dx = 0; dx < COLS; dx++)
                    for (int dy = 0; dy < ROWS; dy++) begin
                        logic [4:0] e;
                        if (cx < dx)      e = D_E;
                        else if (cx > dx) e = D_W;
                        else if (cy < dy) e = D_S;
                        else if (cy > dy) e = D_N;
                        else              e = D_L;
                        try_case((cx != dx) ? "R2" : "R3", cx, cy, dx, dy, 4'b0000, e, 1'b0);
                    end
    endtask

    task automatic test_x_first();
        try_case("R2", 1, 1, 3, 2, B_S, D_E, 1'b0);
        try_case("R2", 2, 1, 0, 3, B_N | B_S, D_W, 1'b0);
    endtask

    task automatic test_y_when_aligned();
        try_case("R3", 2, 0, 2, 3, B_E | B_W, D_S, 1'b0);
        try_case("R3", 2, 3, 2, 1, B_E, D_N, 1'b0);
    endtask

    task automatic test_vertical_detour();
        try_case("R4", 1, 1, 3, 3, B_E, D_S, 1'b0);
        try_case("R4", 1, 2, 3, 0, B_E, D_N, 1'b0);
        try_case("R4", 2, 1, 0, 3, B_W | B_S, D_N, 1'b0);
        try_case("R4", 1, 0, 3, 2, B_E | B_S, D_0, 1'b1);
    endtask

    task automatic test_row_tie_detour();
        try_case("R5", 1, 1, 3, 1, B_E, D_S, 1'b0);
        try_case("R5", 1, 3, 3, 3, B_E, D_N, 1'b0);
        try_case("R5", 2, 1, 0, 1, B_W | B_S, D_N, 1'b0);
    endtask

    task automatic test_horizontal_detour();
        try_case("R6", 2, 1, 2, 3, B_S, D_E, 1'b0);
        try_case("R6", 2, 2, 2, 0, B_N, D_E, 1'b0);
        try_case("R6", 1, 1, 1, 3, B_S | B_E, D_W, 1'b0);
    endtask

    task automatic test_edges();
        try_case("R7", 3, 0, 3, 3, B_S, D_W, 1'b0);
        try_case("R7", 0, 3, 3, 3, B_E, D_N, 1'b0);
        try_case("R7", 3, 3, 0, 3, B_W | B_N, D_0, 1'b1);
        try_case("R7", 0, 0, 0, 3, B_S | B_E, D_0, 1'b1);
    endtask

    task automatic test_all_down();
        try_case("R8", 1, 1, 2, 2, 4'b1111, D_0, 1'b1);
        try_case("R8", 2, 2, 2, 0, 4'b1111, D_0, 1'b1);
        try_case("R9", 1, 2, 1, 2, 4'b0000, D_L, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        test_reset_state();
        test_arrival();
        test_fault_free_sweep();
        test_x_first();
        test_y_when_aligned();
        test_vertical_detour();
        test_row_tie_detour();
        test_horizontal_detour();
        test_edges();
        test_all_down();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule